// File: doc/BRIEF.md
# Offset-Adjusted Counter Register

This block lets software read and write a 64-bit free-running event or cycle counter as if it were an ordinary register, while the counter itself is never changed. The block holds an offset next to the counter. A read returns the counter plus that offset. A write loads the offset so that the value just written is what the next read sees. After that, the value keeps counting up with the counter.

The `XLEN` parameter selects the register width. At 64 one register covers the whole count. At 32 there are two registers, a low word and a high word, each with its own 32-bit offset. The high word folds in the carry that the low word produces when it is rebuilt.

The `PERF_MODE` parameter selects performance-counter behaviour. In that mode every write leaves the combined offset one lower. This cancels the increment caused by the instruction that does the write. When the counter source is marked invalid, the counter is taken as zero and the block acts as a plain scratch register.

Top module: `cntr_csr_top`

## Requirements
- R1: While reset is asserted, both offsets are cleared. After release and before any write, a low read returns counter[31:0] and a high read returns counter[63:32] (at XLEN 32); at XLEN 64 a read returns the whole counter.
- R2: After a write of V, a read of the same register returns V plus however far the counter has advanced since the write clock edge (low word and 64-bit form).
- R3: While `cnt_vld_i` is 0, the counter is taken as zero. A written value then reads back unchanged whatever `cnt_i` carries.
- R4: With PERF_MODE=1, a low or 64-bit write stores an offset one below the ordinary one. A read with the counter unchanged then returns V-1.
- R5: A high read returns bits 63:32 of counter + {high offset, low offset}. A high write of V sets the high offset to V - counter[63:32] - c, where c is the carry out of counter[31:0] + low offset. With the counter unchanged, the high read then returns V (PERF_MODE=0).
- R6: With PERF_MODE=1, a high write first applies the R5 computation. It then lowers the 64-bit {high, low} offset by one: the low offset decrements, and the high offset also decrements when the low offset was zero.
- R7: A write takes effect at the clock edge. A read in the same cycle as the write returns the value from before the write.
- R8: All sums and differences wrap modulo 2^32 (each offset) or 2^64, and no overflow is flagged. Carries pass from the low word into the high read value.
- R9: At XLEN 32, only `csr_wdata_i[31:0]` is used, and a low write leaves the high offset unchanged. At XLEN 64, `csr_hi_sel_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cnt_i | input | 64 | Free-running counter value |
| cnt_vld_i | input | 1 | Counter source present; 0 means the counter is read as zero |
| csr_we_i | input | 1 | Register write strobe |
| csr_hi_sel_i | input | 1 | Selects the high word (XLEN 32 only) |
| csr_wdata_i | input | 64 | Write data; at XLEN 32 only bits 31:0 are used |
| csr_rdata_o | output | XLEN | Read data for the selected word |

## Verification
The read path has no register, so a read result appears in the same cycle as its select and counter inputs. A write appears in the read data only in the cycle after its clock edge. The bench drives each cycle's inputs just after the rising edge and compares at the falling edge of that same cycle. The expected values are taken from the reference offsets before they are updated for that cycle's write. This makes a same-cycle read show the old value and the next cycle show the new one. A reference 64-bit offset per instance, updated with the carry rule, supplies every expected value, including reads just across the 32-bit carry boundary.

// File: rtl/cntr_csr_pkg.sv
package cntr_csr_pkg;
   localparam int unsigned CNT_W  = 64;
   localparam int unsigned HALF_W = CNT_W / 2;

   typedef logic [CNT_W-1:0]  cnt_t;
   typedef logic [HALF_W-1:0] half_t;

   // carry out of a half-width addition
   function automatic logic half_carry(input half_t a, input half_t b);
      logic [HALF_W:0] s;
      s = {1'b0, a} + {1'b0, b};
      return s[HALF_W];
   endfunction
endpackage

// File: rtl/cntr_csr_src.sv
module cntr_csr_src
   import cntr_csr_pkg::*;
(
   input  cnt_t cnt_i,
   input  logic vld_i,
   output cnt_t ctr_o
);
   // unbound source reads as zero
   assign ctr_o = vld_i ? cnt_i : '0;
endmodule

// File: rtl/cntr_csr_offs.sv
module cntr_csr_offs
   import cntr_csr_pkg::*;
#(
   parameter int unsigned XLEN      = 32,
   parameter int unsigned PERF_MODE = 0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic we_i,
   input  logic hi_sel_i,
   input  cnt_t wdata_i,
   input  cnt_t ctr_i,
   output cnt_t off_o
);
   localparam cnt_t  PERF_W = cnt_t'(PERF_MODE);
   localparam half_t PERF_H = half_t'(PERF_MODE);
   localparam half_t ONE_H  = half_t'(1);

   generate
      if (XLEN == CNT_W) begin : g_wide
         cnt_t off_q, off_d;
         logic unused_sel;
         assign unused_sel = hi_sel_i;

         always_comb off_d = wdata_i - ctr_i - PERF_W;

         always_ff @(posedge clk_i) begin
            if (!rst_ni)   off_q <= '0;
            else if (we_i) off_q <= off_d;
         end
         assign off_o = off_q;
      end else begin : g_split
         half_t lo_q, hi_q, lo_d, hi_d, hi_base;
         logic  cy;
         logic  unused_wdata;
         assign unused_wdata = ^wdata_i[CNT_W-1:HALF_W];

         always_comb begin
            // carry the low word produces when it is rebuilt
            cy      = half_carry(ctr_i[HALF_W-1:0], lo_q);
            hi_base = wdata_i[HALF_W-1:0] - ctr_i[CNT_W-1:HALF_W] - half_t'(cy);
            lo_d    = lo_q;
            hi_d    = hi_q;
            if (hi_sel_i) begin
               hi_d = hi_base;
               if (PERF_MODE != 0) begin
                  // 64-bit decrement of {hi, lo}
                  if (lo_q == '0) hi_d = hi_base - ONE_H;
                  lo_d = lo_q - ONE_H;
               end
            end else begin
               lo_d = wdata_i[HALF_W-1:0] - ctr_i[HALF_W-1:0] - PERF_H;
            end
         end

         always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
               lo_q <= '0;
               hi_q <= '0;
            end else if (we_i) begin
               lo_q <= lo_d;
               hi_q <= hi_d;
            end
         end
         assign off_o = {hi_q, lo_q};
      end
   endgenerate
endmodule

// File: rtl/cntr_csr_rdmux.sv
module cntr_csr_rdmux
   import cntr_csr_pkg::*;
#(
   parameter int unsigned XLEN = 32
) (
   input  cnt_t            ctr_i,
   input  cnt_t            off_i,
   input  logic            hi_sel_i,
   output logic [XLEN-1:0] rdata_o
);
   cnt_t sum;
   assign sum = ctr_i + off_i;

   generate
      if (XLEN == CNT_W) begin : g_wide
         logic unused_sel;
         assign unused_sel = hi_sel_i;
         assign rdata_o    = sum;
      end else begin : g_split
         assign rdata_o = hi_sel_i ? sum[CNT_W-1:HALF_W] : sum[HALF_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/cntr_csr_top.sv
module cntr_csr_top
   import cntr_csr_pkg::*;
#(
   parameter int unsigned XLEN      = 32,
   parameter int unsigned PERF_MODE = 0
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic [63:0]     cnt_i,
   input  logic            cnt_vld_i,
   input  logic            csr_we_i,
   input  logic            csr_hi_sel_i,
   input  logic [63:0]     csr_wdata_i,
   output logic [XLEN-1:0] csr_rdata_o
);
   generate
      if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
         $error("cntr_csr_top: XLEN must be 32 or 64");
      end
      if (PERF_MODE > 1) begin : g_bad_perf
         $error("cntr_csr_top: PERF_MODE must be 0 or 1");
      end
   endgenerate

   cnt_t ctr, off;

   cntr_csr_src u_src (
      .cnt_i (cnt_i),
      .vld_i (cnt_vld_i),
      .ctr_o (ctr)
   );

   cntr_csr_offs #(.XLEN(XLEN), .PERF_MODE(PERF_MODE)) u_offs (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .we_i     (csr_we_i),
      .hi_sel_i (csr_hi_sel_i),
      .wdata_i  (csr_wdata_i),
      .ctr_i    (ctr),
      .off_o    (off)
   );

   cntr_csr_rdmux #(.XLEN(XLEN)) u_rd (
      .ctr_i    (ctr),
      .off_i    (off),
      .hi_sel_i (csr_hi_sel_i),
      .rdata_o  (csr_rdata_o)
   );
endmodule

// File: rtl/cntr_csr_chk.sv
module cntr_csr_chk #(
   parameter int unsigned XLEN      = 32,
   parameter int unsigned PERF_MODE = 0
) (
   input logic            clk_i,
   input logic            rst_ni,
   input logic [63:0]     cnt_i,
   input logic            cnt_vld_i,
   input logic            csr_we_i,
   input logic            csr_hi_sel_i,
   input logic [63:0]     csr_wdata_i,
   input logic [XLEN-1:0] csr_rdata_o
);
   localparam bit            IS64   = (XLEN == 64);
   localparam logic [XLEN-1:0] PERF_V = XLEN'(PERF_MODE);

   logic lo_view;
   assign lo_view = IS64 || !csr_hi_sel_i;

   AST_HOLD_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!$past(csr_we_i) && $stable(cnt_i) && $stable(cnt_vld_i) && $stable(csr_hi_sel_i))
      |-> $stable(csr_rdata_o)); // R7

   AST_LO_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(csr_we_i) && $past(lo_view) && lo_view && $stable(cnt_i) && $stable(cnt_vld_i))
      |-> (csr_rdata_o == XLEN'($past(csr_wdata_i)) - PERF_V)); // R2

   AST_SCRATCH_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(csr_we_i) && !$past(cnt_vld_i) && !cnt_vld_i && $past(lo_view) && lo_view)
      |-> (csr_rdata_o == XLEN'($past(csr_wdata_i)) - PERF_V)); // R3

   AST_COUNT_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!$past(csr_we_i) && cnt_vld_i && $past(cnt_vld_i) && lo_view && $past(lo_view))
      |-> (csr_rdata_o == $past(csr_rdata_o) + XLEN'(cnt_i - $past(cnt_i)))); // R8

   generate
      if (!IS64 && PERF_MODE == 0) begin : g_hi
         AST_HI_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ($past(csr_we_i) && $past(csr_hi_sel_i) && csr_hi_sel_i
             && $stable(cnt_i) && $stable(cnt_vld_i))
            |-> (csr_rdata_o == XLEN'($past(csr_wdata_i[31:0])))); // R5
      end
   endgenerate
endmodule

bind cntr_csr_top cntr_csr_chk #(.XLEN(XLEN), .PERF_MODE(PERF_MODE)) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .cnt_i        (cnt_i),
   .cnt_vld_i    (cnt_vld_i),
   .csr_we_i     (csr_we_i),
   .csr_hi_sel_i (csr_hi_sel_i),
   .csr_wdata_i  (csr_wdata_i),
   .csr_rdata_o  (csr_rdata_o)
);

// File: tb/cntr_csr_top_tb_top.sv
module cntr_csr_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] cnt = 64'h0000_0005_FFFF_FFF0;
   logic        vld = 1'b1;
   logic        we = 1'b0;
   logic        sel = 1'b0;
   logic [63:0] wd = '0;
   logic [31:0] rd_a, rd_p;
   logic [63:0] rd_w;

   always #2 clk = ~clk;

   cntr_csr_top #(.XLEN(32), .PERF_MODE(0)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .cnt_i(cnt), .cnt_vld_i(vld), .csr_we_i(we),
      .csr_hi_sel_i(sel), .csr_wdata_i(wd), .csr_rdata_o(rd_a));
   cntr_csr_top #(.XLEN(32), .PERF_MODE(1)) dut_perf_i (
      .clk_i(clk), .rst_ni(rst_n), .cnt_i(cnt), .cnt_vld_i(vld), .csr_we_i(we),
      .csr_hi_sel_i(sel), .csr_wdata_i(wd), .csr_rdata_o(rd_p));
   cntr_csr_top #(.XLEN(64), .PERF_MODE(0)) dut_wide_i (
      .clk_i(clk), .rst_ni(rst_n), .cnt_i(cnt), .cnt_vld_i(vld), .csr_we_i(we),
      .csr_hi_sel_i(sel), .csr_wdata_i(wd), .csr_rdata_o(rd_w));

   typedef struct {
      logic [31:0] exp_a;
      logic [31:0] exp_p;
      logic [63:0] exp_w;
      string       req;
   } sb_item_t;

   sb_item_t    sb_q[$];
   int          n_chk = 0;
   int          n_fail = 0;
   bit          done = 1'b0;
   logic [63:0] m_a = '0, m_p = '0, m_w = '0;
   logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;

   function automatic logic [31:0] rd32(input logic [63:0] off, input logic s,
                                        input logic [63:0] c);
      logic [63:0] t;
      t = c + off;
      return s ? t[63:32] : t[31:0];
   endfunction

   function automatic logic [63:0] wr32(input logic [63:0] off, input logic s,
                                        input logic [63:0] w, input logic [63:0] c,
                                        input bit perf);
      logic [63:0] n;
      logic [32:0] cs;
      n = off;
      if (!s) begin
         n[31:0] = w[31:0] - c[31:0] - (perf ? 32'd1 : 32'd0);
      end else begin
         cs       = {1'b0, c[31:0]} + {1'b0, off[31:0]};
         n[63:32] = w[31:0] - c[63:32] - {31'd0, cs[32]};
         if (perf) n = n - 64'd1;
      end
      return n;
   endfunction

   task automatic step(input bit w_en, input bit s, input logic [63:0] wdat,
                       input logic [63:0] c, input bit v, input string req);
      sb_item_t    it;
      logic [63:0] ctr;
      @(posedge clk);
      #1;
      we = w_en; sel = s; wd = wdat; cnt = c; vld = v;
      ctr = v ? c : 64'd0;
      it.exp_a = rd32(m_a, s, ctr);
      it.exp_p = rd32(m_p, s, ctr);
      it.exp_w = ctr + m_w;
      it.req   = req;
      sb_q.push_back(it);
      if (w_en) begin
         m_a = wr32(m_a, s, wdat, ctr, 1'b0);
         m_p = wr32(m_p, s, wdat, ctr, 1'b1);
         m_w = wdat - ctr;
      end
   endtask

   always @(negedge clk) begin
      if (sb_q.size() > 0) begin
         sb_item_t it;
         it = sb_q.pop_front();
         n_chk += 3;
         if (rd_a !== it.exp_a) begin
            n_fail++;
            $display("FAIL %s plain32: got %h exp %h", it.req, rd_a, it.exp_a);
         end
         if (rd_p !== it.exp_p) begin
            n_fail++;
            $display("FAIL %s perf32: got %h exp %h", it.req, rd_p, it.exp_p);
         end
         if (rd_w !== it.exp_w) begin
            n_fail++;
            $display("FAIL %s wide64: got %h exp %h", it.req, rd_w, it.exp_w);
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      finish_run();
   end

   initial begin
      logic [63:0] c;
      c = 64'h0000_0005_FFFF_FFF0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1: raw counter after reset
      step(0, 0, 0, c, 1, "R1");
      step(0, 1, 0, c, 1, "R1");
      // R7 same-cycle old value, R2/R4 readback
      step(1, 0, 64'h100, c, 1, "R7");
      step(0, 0, 0, c, 1, "R2 R4");
      c = c + 3;
      step(0, 0, 0, c, 1, "R2");
      // R8 low word near wrap, carry into high read
      step(1, 0, 64'hFFFF_FFF0, c, 1, "R8");
      c = c + 64'h20;
      step(0, 1, 0, c, 1, "R8");
      step(0, 0, 0, c, 1, "R8");
      // R5 high write with carry; R9 upper wdata ignored
      step(1, 1, 64'hDEAD_0000_1234_5678, c, 1, "R9");
      step(0, 1, 0, c, 1, "R5");
      step(0, 0, 0, c, 1, "R9 low kept");
      c = c + 5;
      step(0, 1, 0, c, 1, "R5");
      // R6 perf borrow: perf low offset becomes zero, then high write
      step(1, 0, {32'd0, c[31:0] + 32'd1}, c, 1, "R4");
      step(1, 1, 64'h77, c, 1, "R6");
      step(0, 1, 0, c, 1, "R6");
      step(0, 0, 0, c, 1, "R6");
      // R3 scratch behaviour
      step(1, 0, 64'hCAFE, 64'h1111_2222_3333_4444, 0, "R3");
      step(0, 0, 0, 64'h5555_6666_7777_8888, 0, "R3");
      step(1, 1, 64'hBEEF, 64'h9999_0000_AAAA_BBBB, 0, "R3");
      step(0, 1, 0, 64'h0123_4567_89AB_CDEF, 0, "R3");
      // R9: hi select toggled on wide instance, counter held
      step(0, 1, 0, c, 1, "R9");
      step(0, 0, 0, c, 1, "R9");
      // mixed traffic
      for (int i = 0; i < 400; i++) begin
         lfsr = lfsr ^ (lfsr << 13);
         lfsr = lfsr ^ (lfsr >> 7);
         lfsr = lfsr ^ (lfsr << 17);
         if (lfsr[5:4] == 2'd0) c = {c[63:32], 32'hFFFF_FFFC};
         else c = c + {60'd0, lfsr[9:6]};
         step(lfsr[0] & lfsr[1], lfsr[2], {lfsr[40:20], lfsr[63:21]}, c,
              lfsr[12:10] != 3'd0, "R2 R5 R8 mix");
      end
      step(0, 0, 0, c, 1, "R2");
      @(posedge clk);
      @(posedge clk);
      finish_run();
   end
endmodule